// File: doc/BRIEF.md
# Three-Bank Level Interrupt Controller with Direct Mirror Bits

This block gathers level-sensitive interrupt requests from three groups of sources and presents them to a processor through a small 32-bit register window. Group 0 holds 8 basic sources. Groups 1 and 2 hold 32 sources each. Every source has its own mask bit. Software sets a mask bit through a per-group enable register and clears it through a per-group disable register. A per-group pending register shows which unmasked sources are requesting service.

The group 0 pending word also works as a top-level status word, and it is the only word a handler needs to read first. It carries two summary bits, one for group 1 and one for group 2. It also carries direct mirror bits for eleven frequently serviced sources in groups 1 and 2. A mirrored source is left out of its group's summary bit, so a handler that decodes the mirror bits does not also have to walk the group register. A single request line goes high whenever the group 0 pending word is non-zero.

The register bus has no handshake. A write takes effect at the clock edge where `bus_we` is high. Reads are combinational on `bus_addr`. Bits [1:0] of the address are ignored.

Top module: `banked_irq_ctrl`

## Requirements
- R1: The group 1 pending word (offset 0x04) and the group 2 pending word (offset 0x08) each read as that group's raw source vector ANDed with its mask.
- R2: Each group has an enable register and a disable register. The enable registers are at 0x18 (group 0), 0x10 (group 1) and 0x14 (group 2). The disable registers are at 0x24 (group 0), 0x1c (group 1) and 0x20 (group 2). Writing a 1 to an enable bit unmasks that source, and writing a 1 to a disable bit masks it. Zero bits in the write data leave the mask unchanged.
- R3: After reset every source is masked. All enable registers read zero, all pending words read zero and the request line is low.
- R4: Bits 7:0 of the group 0 pending word (offset 0x00) read as the basic sources ANDed with the group 0 mask.
- R5: Group 0 pending bit 8 is set when any unmasked, non-mirrored group 1 source is active. Bit 9 does the same for group 2.
- R6: Bits 10 to 14 of the group 0 pending word mirror group 1 sources 7, 9, 10, 18 and 19, in that order, each gated by its group 1 mask. Bits 15 to 20 mirror group 2 sources 21, 22, 23, 24, 25 and 30, in that order, each gated by its group 2 mask.
- R7: A mirrored source sets both its mirror bit and its own bit in its group's pending word. It never sets the summary bit 8 or 9.
- R8: Writes to the group 0 enable or disable register at bit positions 8 and above have no effect. A mirror bit can be masked only through its own group's registers, and the summary bits cannot be masked on their own.
- R9: Bits 31:21 of the group 0 pending word always read as zero.
- R10: The request output `irq_out` is high exactly when the group 0 pending word is non-zero.
- R11: Reading an enable register returns that group's current mask. Reading a disable register returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_addr | input | 6 | Byte address of the register access |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data |
| src_b0 | input | 8 | Group 0 basic level sources |
| src_b1 | input | 32 | Group 1 level sources |
| src_b2 | input | 32 | Group 2 level sources |
| irq_out | output | 1 | Processor interrupt request |

## Verification
The bench aims at the split between mirrored and non-mirrored sources. A design that let a mirrored source also raise its summary bit would report the request twice. A design with a mirror table off by one entry would set the wrong bit 10 to 20. It also writes all ones to the group 0 mask registers at the summary and mirror positions: a design that accepted those bits would unmask a mirror bit against its group mask, or hide a summary bit. Two further checks catch mask registers that lose the bits a write leaves at zero, and disable addresses that echo the mask instead of reading zero.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  localparam int unsigned DATA_W   = 32;
  localparam int unsigned ADDR_W   = 6;
  localparam int unsigned BASIC_N  = 8;
  localparam int unsigned GRP_N    = 32;
  localparam int unsigned SC1_N    = 5;
  localparam int unsigned SC2_N    = 6;
  localparam int unsigned SUM1_BIT = BASIC_N;
  localparam int unsigned SUM2_BIT = BASIC_N + 1;
  localparam int unsigned SC1_LSB  = BASIC_N + 2;
  localparam int unsigned SC2_LSB  = SC1_LSB + SC1_N;
  localparam int unsigned P0_USED  = SC2_LSB + SC2_N;

  // word index (byte offset / 4) of each register
  typedef enum logic [3:0] {
    RS_PEND0 = 4'd0,
    RS_PEND1 = 4'd1,
    RS_PEND2 = 4'd2,
    RS_EN1   = 4'd4,
    RS_EN2   = 4'd5,
    RS_EN0   = 4'd6,
    RS_DIS1  = 4'd7,
    RS_DIS2  = 4'd8,
    RS_DIS0  = 4'd9
  } reg_sel_e;

  // group 1 source feeding mirror bit SC1_LSB+k
  function automatic int unsigned sc1_src(input int unsigned k);
    case (k)
      0:       return 7;
      1:       return 9;
      2:       return 10;
      3:       return 18;
      default: return 19;
    endcase
  endfunction

  // group 2 source feeding mirror bit SC2_LSB+k
  function automatic int unsigned sc2_src(input int unsigned k);
    case (k)
      0:       return 21;
      1:       return 22;
      2:       return 23;
      3:       return 24;
      4:       return 25;
      default: return 30;
    endcase
  endfunction

  function automatic logic [GRP_N-1:0] sc1_mask();
    logic [GRP_N-1:0] m;
    m = '0;
    for (int unsigned k = 0; k < SC1_N; k++) m[sc1_src(k)] = 1'b1;
    return m;
  endfunction

  function automatic logic [GRP_N-1:0] sc2_mask();
    logic [GRP_N-1:0] m;
    m = '0;
    for (int unsigned k = 0; k < SC2_N; k++) m[sc2_src(k)] = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/irqc_mask_reg.sv
module irqc_mask_reg #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_en,
  input  logic         clr_en,
  input  logic [W-1:0] bits,
  output logic [W-1:0] mask_q
);

  logic [W-1:0] mask_d;
  logic         upd;

  always_comb begin
    mask_d = mask_q;
    if (set_en) mask_d = mask_d | bits;
    if (clr_en) mask_d = mask_d & ~bits;
  end

  assign upd = set_en | clr_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   mask_q <= '0;
    else if (upd) mask_q <= mask_d;
  end

endmodule

// File: rtl/irqc_pend_merge.sv
module irqc_pend_merge
  import irqc_pkg::*;
(
  input  logic [BASIC_N-1:0] pend_basic,
  input  logic [GRP_N-1:0]   pend_g1,
  input  logic [GRP_N-1:0]   pend_g2,
  output logic [DATA_W-1:0]  pend_top
);

  localparam logic [GRP_N-1:0] SC1_M = sc1_mask();
  localparam logic [GRP_N-1:0] SC2_M = sc2_mask();

  logic [SC1_N-1:0] mir1;
  logic [SC2_N-1:0] mir2;

  for (genvar k = 0; k < SC1_N; k++) begin : g_mir1
    assign mir1[k] = pend_g1[sc1_src(k)];
  end

  for (genvar k = 0; k < SC2_N; k++) begin : g_mir2
    assign mir2[k] = pend_g2[sc2_src(k)];
  end

  always_comb begin
    pend_top                          = '0;
    pend_top[BASIC_N-1:0]             = pend_basic;
    pend_top[SUM1_BIT]                = |(pend_g1 & ~SC1_M);
    pend_top[SUM2_BIT]                = |(pend_g2 & ~SC2_M);
    pend_top[SC1_LSB +: SC1_N]        = mir1;
    pend_top[SC2_LSB +: SC2_N]        = mir2;
  end

endmodule

// File: rtl/irqc_regif.sv
module irqc_regif
  import irqc_pkg::*;
(
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_we,
  input  logic [DATA_W-1:0]  pend_top,
  input  logic [GRP_N-1:0]   pend_g1,
  input  logic [GRP_N-1:0]   pend_g2,
  input  logic [BASIC_N-1:0] en_b0,
  input  logic [GRP_N-1:0]   en_b1,
  input  logic [GRP_N-1:0]   en_b2,
  output logic [2:0]         set_en,
  output logic [2:0]         clr_en,
  output logic [DATA_W-1:0]  bus_rdata
);

  logic [3:0] sel;
  assign sel = bus_addr[ADDR_W-1:2];

  always_comb begin
    set_en = '0;
    clr_en = '0;
    if (bus_we) begin
      case (sel)
        RS_EN0:  set_en[0] = 1'b1;
        RS_EN1:  set_en[1] = 1'b1;
        RS_EN2:  set_en[2] = 1'b1;
        RS_DIS0: clr_en[0] = 1'b1;
        RS_DIS1: clr_en[1] = 1'b1;
        RS_DIS2: clr_en[2] = 1'b1;
        default: ;
      endcase
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (sel)
      RS_PEND0: bus_rdata = pend_top;
      RS_PEND1: bus_rdata = pend_g1;
      RS_PEND2: bus_rdata = pend_g2;
      RS_EN0:   bus_rdata[BASIC_N-1:0] = en_b0;
      RS_EN1:   bus_rdata = en_b1;
      RS_EN2:   bus_rdata = en_b2;
      default:  bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/banked_irq_ctrl.sv
module banked_irq_ctrl
  import irqc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [5:0]        bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [7:0]        src_b0,
  input  logic [31:0]       src_b1,
  input  logic [31:0]       src_b2,
  output logic              irq_out
);

  logic [1:0]         rst_pipe;
  logic               rst_sync_n;
  logic [2:0]         set_en;
  logic [2:0]         clr_en;
  logic [BASIC_N-1:0] en_b0;
  logic [GRP_N-1:0]   en_b1;
  logic [GRP_N-1:0]   en_b2;
  logic [BASIC_N-1:0] pend_basic;
  logic [GRP_N-1:0]   pend_g1;
  logic [GRP_N-1:0]   pend_g2;
  logic [DATA_W-1:0]  pend_top;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  irqc_mask_reg #(.W(BASIC_N)) u_mask0 (
    .clk(clk), .rst_n(rst_sync_n), .set_en(set_en[0]), .clr_en(clr_en[0]),
    .bits(bus_wdata[BASIC_N-1:0]), .mask_q(en_b0)
  );

  irqc_mask_reg #(.W(GRP_N)) u_mask1 (
    .clk(clk), .rst_n(rst_sync_n), .set_en(set_en[1]), .clr_en(clr_en[1]),
    .bits(bus_wdata[GRP_N-1:0]), .mask_q(en_b1)
  );

  irqc_mask_reg #(.W(GRP_N)) u_mask2 (
    .clk(clk), .rst_n(rst_sync_n), .set_en(set_en[2]), .clr_en(clr_en[2]),
    .bits(bus_wdata[GRP_N-1:0]), .mask_q(en_b2)
  );

  assign pend_basic = src_b0 & en_b0;
  assign pend_g1    = src_b1 & en_b1;
  assign pend_g2    = src_b2 & en_b2;

  irqc_pend_merge u_merge (
    .pend_basic(pend_basic), .pend_g1(pend_g1), .pend_g2(pend_g2),
    .pend_top(pend_top)
  );

  irqc_regif u_regif (
    .bus_addr(bus_addr), .bus_we(bus_we), .pend_top(pend_top),
    .pend_g1(pend_g1), .pend_g2(pend_g2), .en_b0(en_b0), .en_b1(en_b1),
    .en_b2(en_b2), .set_en(set_en), .clr_en(clr_en), .bus_rdata(bus_rdata)
  );

  assign irq_out = |pend_top;

endmodule

// File: rtl/irqc_checker.sv
module irqc_checker
  import irqc_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic [5:0]  bus_addr,
  input logic        bus_we,
  input logic [31:0] bus_wdata,
  input logic [31:0] bus_rdata,
  input logic [31:0] src_b1,
  input logic        irq_out,
  input logic [7:0]  en_b0,
  input logic [31:0] en_b1
);

  localparam logic [31:0] SC1_M = sc1_mask();

  // R10: request line agrees with the status word read back
  a_r10_irq_matches_top: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr[5:2] == 4'd0) |-> (irq_out == (bus_rdata != 32'd0)));

  // R9: unused top bits stay zero
  a_r9_top_high_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr[5:2] == 4'd0) |-> (bus_rdata[31:21] == 11'd0));

  // R11: disable addresses read zero
  a_r11_disable_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr[5:2] >= 4'd7 && bus_addr[5:2] <= 4'd9) |-> (bus_rdata == 32'd0));

  // R2: enable write sets every written one
  a_r2_enable_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr[5:2] == 4'd4) |=> ((en_b1 & $past(bus_wdata)) == $past(bus_wdata)));

  // R2: disable write clears every written one
  a_r2_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr[5:2] == 4'd7) |=> ((en_b1 & $past(bus_wdata)) == 32'd0));

  // R8: group 0 enable only reaches the basic bits
  a_r8_basic_only: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr[5:2] == 4'd6) |=> (en_b0 == ($past(en_b0) | $past(bus_wdata[7:0]))));

  // R7: mirrored sources never raise the group 1 summary
  a_r7_summary_excludes_mirror: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr[5:2] == 4'd0 && ((src_b1 & en_b1 & ~SC1_M) == 32'd0)) |-> !bus_rdata[8]);

endmodule

bind banked_irq_ctrl irqc_checker u_chk (
  .clk(clk), .rst_n(rst_sync_n), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_b1(src_b1),
  .irq_out(irq_out), .en_b0(en_b0), .en_b1(en_b1)
);

// File: tb/banked_irq_ctrl_bench.sv
module banked_irq_ctrl_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [5:0]  bus_addr;
  logic        bus_we;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [7:0]  src_b0;
  logic [31:0] src_b1;
  logic [31:0] src_b2;
  logic        irq_out;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  banked_irq_ctrl u_banked_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_b0(src_b0),
    .src_b1(src_b1), .src_b2(src_b2), .irq_out(irq_out)
  );

  typedef struct packed {
    logic [7:0]  s0;
    logic [31:0] s1;
    logic [31:0] s2;
    logic [31:0] top;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{8'h00, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000},
    '{8'h81, 32'h0000_0000, 32'h0000_0000, 32'h0000_0081},
    '{8'h00, 32'h0000_0080, 32'h0000_0000, 32'h0000_0400},
    '{8'h00, 32'h0000_0001, 32'h0000_0000, 32'h0000_0100},
    '{8'h00, 32'h0000_0000, 32'h4000_0000, 32'h0010_0000},
    '{8'h00, 32'h0000_0000, 32'h0000_0001, 32'h0000_0200},
    '{8'h00, 32'h0008_0008, 32'h0000_0000, 32'h0000_4100},
    '{8'h00, 32'h0000_0000, 32'h0220_0000, 32'h0008_8000},
    '{8'hFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h001F_FFFF},
    '{8'h00, 32'h0000_0600, 32'h0000_0000, 32'h0000_1800}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd_chk(input logic [5:0] a, input logic [31:0] exp, input string tag);
    bus_addr = a; bus_we = 1'b0;
    #1;
    check(tag, bus_rdata, exp);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    bus_addr = '0; bus_we = 1'b0; bus_wdata = '0;
    src_b0 = '0; src_b1 = '0; src_b2 = '0;
    do_reset();

    // R3: everything masked after reset
    src_b0 = 8'hFF; src_b1 = '1; src_b2 = '1;
    @(negedge clk);
    rd_chk(6'h18, 32'h0, "R3 enable0 reset");
    rd_chk(6'h10, 32'h0, "R3 enable1 reset");
    rd_chk(6'h14, 32'h0, "R3 enable2 reset");
    rd_chk(6'h00, 32'h0, "R3 top pending reset");
    check("R3 irq reset", {31'd0, irq_out}, 32'd0);

    // R8: group 0 enable writes above bit 7 are dropped
    wr(6'h18, 32'hFFFF_FF00);
    rd_chk(6'h18, 32'h0, "R8 enable0 high bits ignored");
    rd_chk(6'h00, 32'h0, "R8 mirror not unmasked via group 0");

    // R4 and R2: basic bits, zero bits keep mask
    wr(6'h18, 32'h0000_0005);
    rd_chk(6'h00, 32'h0000_0005, "R4 basic pending gated");
    wr(6'h18, 32'h0000_0002);
    rd_chk(6'h18, 32'h0000_0007, "R2 enable zeros no effect");

    // unmask everything for the table
    wr(6'h18, 32'h0000_00FF);
    wr(6'h10, 32'hFFFF_FFFF);
    wr(6'h14, 32'hFFFF_FFFF);

    // R1 R5 R6 R7 R9 R10: vector walk
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      src_b0 = VECS[i].s0; src_b1 = VECS[i].s1; src_b2 = VECS[i].s2;
      rd_chk(6'h00, VECS[i].top, $sformatf("R5/R6/R7/R9 top word vec %0d", i));
      rd_chk(6'h04, VECS[i].s1, $sformatf("R1 group1 pending vec %0d", i));
      rd_chk(6'h08, VECS[i].s2, $sformatf("R1 group2 pending vec %0d", i));
      check($sformatf("R10 irq vec %0d", i), {31'd0, irq_out}, {31'd0, VECS[i].top != 0});
    end

    // R2: disable a mirrored source in its own group
    @(negedge clk);
    src_b0 = '0; src_b1 = 32'h0000_0080; src_b2 = '0;
    wr(6'h1c, 32'h0000_0080);
    rd_chk(6'h00, 32'h0, "R2 disabled mirror source gone");
    rd_chk(6'h04, 32'h0, "R2 disabled source pending1");
    rd_chk(6'h10, 32'hFFFF_FF7F, "R2 disable zeros no effect");
    check("R10 irq low when top zero", {31'd0, irq_out}, 32'd0);
    rd_chk(6'h1c, 32'h0, "R11 disable reads zero");

    // R8: group 0 disable cannot hide summary or mirror bits
    wr(6'h24, 32'h001F_FF00);
    src_b1 = 32'h0000_0201;
    rd_chk(6'h00, 32'h0000_0900, "R8 summary and mirror unmaskable in group 0");
    rd_chk(6'h18, 32'h0000_00FF, "R8 disable0 high bits ignored");

    // R11: enable read returns mask
    wr(6'h10, 32'h0000_0080);
    rd_chk(6'h10, 32'hFFFF_FFFF, "R11 enable1 readback");

    // R3: reset again masks all
    do_reset();
    rd_chk(6'h10, 32'h0, "R3 enable1 after second reset");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule